// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs a single bit of a non-restoring binary division on each accepted operation. It holds three status bits: Q (sign of the last partial remainder), M (sign of the divisor) and T (the bit exchanged with the remainder shift and with quotient collection). A controller outside the block chooses the operation on each cycle, supplies the divisor and the current partial remainder, and writes the returned remainder back to its own storage. The block holds no register file.

One set-up operation prepares the flags. After that, each step operation shifts T into the partial remainder. It then adds or subtracts the divisor, chosen by the previous Q and M, and leaves the new quotient bit in T. A rotate-through-T operation is also provided. It shifts that quotient bit into a second word while the next dividend bit moves out into T. For an unsigned 64-by-32 division, the controller issues one unsigned set-up and then 32 pairs of operations: a rotate on the low dividend word followed by a step on the high word. A final rotate then leaves the quotient in the low word. Correcting the sign of a signed quotient is the controller's job.

Results are registered. An operation accepted at a rising edge is visible on the outputs after that edge.

Top module: `nrd_step_unit`

## Requirements
- R1: After reset, `rem_out`, `q_flag`, `m_flag` and `t_flag` are all 0.
- R2: The unsigned set-up (`op_sel` = 2'b00, `op_valid` = 1) clears Q, M and T. `rem_out` is left unchanged.
- R3: The signed set-up (`op_sel` = 2'b01) loads Q from `rem_in[WIDTH-1]` and M from `divisor[WIDTH-1]`, and sets T to Q XOR M. `rem_out` is left unchanged.
- R4: A step (`op_sel` = 2'b10) forms S = {`rem_in[WIDTH-2:0]`, T}. It writes S − `divisor` when the previous Q equals M, and S + `divisor` otherwise, modulo 2^WIDTH. M is unchanged.
- R5: After a step, the new Q is `rem_in[WIDTH-1]` XOR M XOR C. C is the borrow out of the subtraction, or the carry out of the addition.
- R6: After a step, T is 1 exactly when the new Q equals M.
- R7: A rotate (`op_sel` = 2'b11) writes {`rem_in[WIDTH-2:0]`, T} to `rem_out` and loads T from `rem_in[WIDTH-1]`. Q and M are unchanged.
- R8: While `op_valid` is 0, `rem_out`, Q, M and T all keep their values, whatever is on the other inputs.
- R9: Take a dividend {H, L} with H < D and D ≠ 0. An unsigned set-up, then 32 rotate/step pairs (rotate on L, step on H, each writing back its own word), then a final rotate on L leave ({H, L} / D) on `rem_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accepts the operation on `op_sel` at this edge |
| op_sel | input | 2 | 00 unsigned set-up, 01 signed set-up, 10 step, 11 rotate through T |
| divisor | input | WIDTH | Divisor operand |
| rem_in | input | WIDTH | Partial remainder, or the word to rotate |
| rem_out | output | WIDTH | Registered result word |
| q_flag | output | 1 | Q status bit |
| m_flag | output | 1 | M status bit |
| t_flag | output | 1 | T status bit |

## Verification
The bench builds the unit with its default WIDTH of 32. At that width it can run complete 64-by-32 unsigned divisions and compare each quotient against integer division, alongside a step-by-step model. The full width also brings the carry and borrow corners within reach: a divisor of all ones, a remainder just below the divisor, and an addition that wraps past 2^32. Signed set-ups with random operand signs drive every combination of previous Q and M into the step logic.

// File: rtl/nrd_pkg.sv
package nrd_pkg;

    typedef enum logic [1:0] {
        NRD_SETUP_U = 2'b00,
        NRD_SETUP_S = 2'b01,
        NRD_STEP    = 2'b10,
        NRD_ROTATE  = 2'b11
    } nrd_op_e;

    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } nrd_flags_t;

endpackage

// File: rtl/nrd_addsub.sv
// Shift-in and conditional add/subtract core of one division step.
module nrd_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic [WIDTH-1:0] divisor,
    input  logic             t_in,
    input  logic             do_sub,
    output logic [WIDTH-1:0] result,
    output logic             carry
);
    localparam int EXT = WIDTH + 1;

    logic [WIDTH-1:0] shifted;
    logic [EXT-1:0]   ext_sum;

    always_comb begin
        shifted = {rem_in[WIDTH-2:0], t_in};
        if (do_sub) begin
            ext_sum = {1'b0, shifted} - {1'b0, divisor};
        end else begin
            ext_sum = {1'b0, shifted} + {1'b0, divisor};
        end
        result = ext_sum[WIDTH-1:0];
        carry  = ext_sum[EXT-1];
    end

    // A borrow means the wrapped difference exceeds the minuend; a carry
    // means the wrapped sum fell below the augend.
    always_comb begin
        if (do_sub) begin
            assert (carry == (result > shifted)) else $error("AST_SUB_BORROW"); // R5
        end else begin
            assert (carry == (result < shifted)) else $error("AST_ADD_CARRY"); // R5
        end
    end

endmodule

// File: rtl/nrd_qsel.sv
// Operation choice and quotient/T bit derivation for one step.
module nrd_qsel (
    input  logic old_q,
    input  logic m_in,
    input  logic msb_cap,
    input  logic carry,
    output logic do_sub,
    output logic q_new,
    output logic t_new
);
    always_comb begin
        do_sub = (old_q == m_in);
        q_new  = msb_cap ^ m_in ^ carry;
        t_new  = (q_new == m_in);
    end

endmodule

// File: rtl/nrd_rotate.sv
// Rotate a word left by one through the T bit.
module nrd_rotate #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_in,
    input  logic             t_in,
    output logic [WIDTH-1:0] word_out,
    output logic             t_out
);
    always_comb begin
        word_out = {word_in[WIDTH-2:0], t_in};
        t_out    = word_in[WIDTH-1];
    end

endmodule

// File: rtl/nrd_step_unit.sv
module nrd_step_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] divisor,
    input  logic [WIDTH-1:0] rem_in,
    output logic [WIDTH-1:0] rem_out,
    output logic             q_flag,
    output logic             m_flag,
    output logic             t_flag
);
    import nrd_pkg::*;

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] rem;
        nrd_flags_t       fl;
    } nrd_state_t;

    nrd_state_t st_d, st_q;
    nrd_op_e    op_e;

    logic [WIDTH-1:0] step_res_d;
    logic             step_carry_d;
    logic             step_sub_d;
    logic             step_q_d;
    logic             step_t_d;
    logic [WIDTH-1:0] rot_word_d;
    logic             rot_t_d;

    assign op_e = nrd_op_e'(op_sel);

    nrd_qsel i_qsel (
        .old_q   (st_q.fl.q),
        .m_in    (st_q.fl.m),
        .msb_cap (rem_in[MSB]),
        .carry   (step_carry_d),
        .do_sub  (step_sub_d),
        .q_new   (step_q_d),
        .t_new   (step_t_d)
    );

    nrd_addsub #(.WIDTH(WIDTH)) i_addsub (
        .rem_in  (rem_in),
        .divisor (divisor),
        .t_in    (st_q.fl.t),
        .do_sub  (step_sub_d),
        .result  (step_res_d),
        .carry   (step_carry_d)
    );

    nrd_rotate #(.WIDTH(WIDTH)) i_rotate (
        .word_in  (rem_in),
        .t_in     (st_q.fl.t),
        .word_out (rot_word_d),
        .t_out    (rot_t_d)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            unique case (op_e)
                NRD_SETUP_U: begin
                    st_d.fl = '{q: 1'b0, m: 1'b0, t: 1'b0};
                end
                NRD_SETUP_S: begin
                    st_d.fl.q = rem_in[MSB];
                    st_d.fl.m = divisor[MSB];
                    st_d.fl.t = rem_in[MSB] ^ divisor[MSB];
                end
                NRD_STEP: begin
                    st_d.rem  = step_res_d;
                    st_d.fl.q = step_q_d;
                    st_d.fl.t = step_t_d;
                end
                NRD_ROTATE: begin
                    st_d.rem  = rot_word_d;
                    st_d.fl.t = rot_t_d;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rem_out = st_q.rem;
    assign q_flag  = st_q.fl.q;
    assign m_flag  = st_q.fl.m;
    assign t_flag  = st_q.fl.t;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(rem_out) && $stable(q_flag) && $stable(m_flag) && $stable(t_flag)); // R8

    AST_USETUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == 2'b00 |=> !q_flag && !m_flag && !t_flag && $stable(rem_out)); // R2

    AST_SSETUP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == 2'b01 |=> q_flag == $past(rem_in[MSB]) && m_flag == $past(divisor[MSB])
            && t_flag == (q_flag ^ m_flag) && $stable(rem_out)); // R3

    AST_STEP_M_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == 2'b10 |=> $stable(m_flag)); // R4

    AST_STEP_T_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == 2'b10 |=> t_flag == (q_flag == m_flag)); // R6

    AST_ROT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_sel == 2'b11 |=> t_flag == $past(rem_in[MSB]) && rem_out[0] == $past(t_flag)
            && $stable(q_flag) && $stable(m_flag)); // R7

endmodule

// File: tb/test_nrd_step_unit.sv
`timescale 1ns/1ps
module test_nrd_step_unit;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] divisor = '0;
    logic [W-1:0] rem_in = '0;
    logic [W-1:0] rem_out;
    logic         q_flag, m_flag, t_flag;

    always #2.5 clk = ~clk;

    nrd_step_unit #(.WIDTH(W)) i_nrd_step_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .divisor(divisor), .rem_in(rem_in), .rem_out(rem_out),
        .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag)
    );

    typedef struct {
        int           kind;   // 0..3 op code, 4 idle
        logic [W-1:0] rem;
        logic         q, m, t;
        longint       due;
    } exp_t;

    exp_t   sb[$];
    longint cyc = 0;
    int     n_tests = 0;
    int     n_fail = 0;
    bit     done = 0;

    // bench model
    logic [W-1:0] mrem = '0;
    logic         mq = 0, mm = 0, mt = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic issue(input int kind, input logic [W-1:0] dv, input logic [W-1:0] rn,
                         output logic [W-1:0] res);
        exp_t e;
        logic [W-1:0] sh;
        logic [W:0]   ext;
        logic         c;
        case (kind)
            0: begin mq = 0; mm = 0; mt = 0; end
            1: begin mq = rn[W-1]; mm = dv[W-1]; mt = mq ^ mm; end
            2: begin
                sh = {rn[W-2:0], mt};
                if (mq == mm) ext = {1'b0, sh} - {1'b0, dv};
                else          ext = {1'b0, sh} + {1'b0, dv};
                c    = ext[W];
                mrem = ext[W-1:0];
                mq   = rn[W-1] ^ mm ^ c;
                mt   = (mq == mm);
            end
            3: begin mrem = {rn[W-2:0], mt}; mt = rn[W-1]; end
            default: ;
        endcase
        e.kind = kind; e.rem = mrem; e.q = mq; e.m = mm; e.t = mt; e.due = cyc + 1;
        sb.push_back(e);
        op_valid = (kind != 4);
        op_sel   = (kind == 4) ? 2'($urandom) : 2'(kind);
        divisor  = dv;
        rem_in   = rn;
        res      = mrem;
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                case (e.kind)
                    0: begin
                        chk(rem_out == e.rem, "R2 rem", rem_out, e.rem);
                        chk({q_flag, m_flag, t_flag} == 3'b000, "R2 flags", W'({q_flag, m_flag, t_flag}), '0);
                    end
                    1: begin
                        chk(rem_out == e.rem, "R3 rem", rem_out, e.rem);
                        chk({q_flag, m_flag, t_flag} == {e.q, e.m, e.t}, "R3 flags",
                            W'({q_flag, m_flag, t_flag}), W'({e.q, e.m, e.t}));
                    end
                    2: begin
                        chk(rem_out == e.rem, "R4 rem", rem_out, e.rem);
                        chk(m_flag == e.m, "R4 m", W'(m_flag), W'(e.m));
                        chk(q_flag == e.q, "R5 q", W'(q_flag), W'(e.q));
                        chk(t_flag == e.t, "R6 t", W'(t_flag), W'(e.t));
                    end
                    3: begin
                        chk(rem_out == e.rem, "R7 rem", rem_out, e.rem);
                        chk({q_flag, m_flag, t_flag} == {e.q, e.m, e.t}, "R7 flags",
                            W'({q_flag, m_flag, t_flag}), W'({e.q, e.m, e.t}));
                    end
                    default: begin
                        chk(rem_out == e.rem && {q_flag, m_flag, t_flag} == {e.q, e.m, e.t}, "R8 hold",
                            rem_out, e.rem);
                    end
                endcase
            end
        end
    end

    task automatic divide(input logic [W-1:0] hi, input logic [W-1:0] lo, input logic [W-1:0] dv);
        logic [W-1:0]   r1, r2, dummy;
        logic [2*W-1:0] quo;
        r1 = lo; r2 = hi;
        issue(0, dv, 32'h0, dummy);
        for (int i = 0; i < W; i++) begin
            issue(3, 32'h0, r1, r1);
            issue(2, dv, r2, r2);
        end
        issue(3, 32'h0, r1, r1);
        quo = {hi, lo} / {{W{1'b0}}, dv};
        chk(rem_out == quo[W-1:0], "R9 quotient", rem_out, quo[W-1:0]);
    endtask

    initial begin
        logic [W-1:0] x;
        repeat (3) @(negedge clk);
        chk(rem_out == '0 && !q_flag && !m_flag && !t_flag, "R1 reset", rem_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        // rotate and idle behaviour
        issue(3, 32'h0, 32'h8000_0001, x);
        issue(3, 32'h0, 32'h4000_0000, x);
        issue(4, 32'hDEAD_BEEF, 32'h1234_5678, x);
        issue(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, x);
        // signed set-ups and steps covering all Q/M pairs
        for (int k = 0; k < 16; k++) begin
            issue(1, $urandom, $urandom, x);
            issue(2, $urandom, $urandom, x);
            issue(3, 32'h0, $urandom, x);
            issue(2, $urandom, $urandom, x);
            issue(4, $urandom, $urandom, x);
        end
        // carry/borrow corners
        issue(1, 32'h8000_0000, 32'h0000_0000, x);
        issue(2, 32'h8000_0000, 32'hFFFF_FFFF, x);
        issue(2, 32'h0000_0000, 32'h8000_0000, x);
        issue(0, 32'h0, 32'h0, x);
        issue(2, 32'hFFFF_FFFF, 32'h7FFF_FFFF, x);
        // full unsigned divisions
        divide(32'h0, 32'd100, 32'd7);
        divide(32'h0, 32'hFFFF_FFFF, 32'd1);
        divide(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        divide(32'h0000_0002, 32'h0000_0000, 32'h0000_0003);
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] dv;
            dv = $urandom | 32'h1;
            divide($urandom % dv, $urandom, dv);
        end
        issue(4, 32'h0, 32'h0, x);
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule